// File: doc/BRIEF.md
# NAND Command Phase Sequencer

This block runs one asynchronous NAND flash transaction from a small set of registers that a host programs. A write to the control word with its start bit set starts a fixed chain of optional phases: a leading command latch, address cycles, a short programmed data transfer, a trailing command byte, and a wait for the flash to report ready. The chain ends with a completion flag that can raise an interrupt. The sequencer drives the chip enables, the command and address latch enables, the write and read strobes, and an 8-bit data bus. Each strobe width and each gap comes from cycle counts in a timing register.

Each phase is switched on by its own bit in the control word. A single flag decides where the trailing command falls. When the flag is clear it follows the address cycles, which suits a page read. When the flag is set it follows the data bytes, which suits a page program. The ready wait has two modes. It can watch the ready/busy pin, or it can keep reading a status byte until two masked compares both match. Up to four data bytes pass through a response register. The host can abort a running transaction by writing zero to the control word.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset every chip enable is high (inactive), weN and reN are high, cle and ale are low, irq is low and the control word (index 0) reads zero.
- R2: Control word bits: 31 start, 30 leading command, 29 address, 28 data, 27 send, 26 receive, 25 trailing command, 24 trailing-after-data, 16 ready wait. Enabled phases run in the order leading command, address, trailing command (when bit 24 is 0), data, trailing command (when bit 24 is 1), ready wait. A phase whose bit is clear is skipped.
- R3: With bit 24 set, the trailing command byte (register index 5, bits 7:0) is latched after the last data byte.
- R4: Bits 15:8 of the control word are a one-hot chip select. Only that active-low chip enable goes low, and it stays low from the start until the transaction ends. If several bits are set, the lowest one wins.
- R5: Address cycles number bits 3:0 plus one. They are sent least significant byte first: bytes 0..3 come from register index 6 and bytes 4..7 from index 7. Each is latched with ale high and cle low.
- R6: The leading command sends bits 5:4 plus one bytes from register index 4, least significant byte first, each latched with cle high.
- R7: A send data phase writes bits 23:20 plus one bytes (at most 4) from the response register (index 8), low byte first.
- R8: A receive data phase reads the same number of bytes on reN pulses and packs them into the response register, low byte first.
- R9: The timing register (index 3) holds, in cycles: write low [3:0]+1, write high [7:4]+1, read low [11:8]+1, read high [15:12]+1, write-to-busy [19:16]+1, enable setup [23:20]+2, address-to-read [27:24]+3 and address-to-data-write [31:28]+3. The setup runs before the first strobe. The address-to-data gap runs before the data phase and follows the write-high time of the byte before it. The write-to-busy delay also follows that write-high time.
- R10: In the ready wait, if the status mask fields of register index 9 ([31:24] read-status mask, [23:16] its value, [15:8] ready mask, [7:0] its value) are all-zero masks, the wait ends when rbPin is high. Otherwise it repeats status reads until (byte & mask) == value holds for both pairs, and rbPin is ignored.
- R11: Completion sets status bit 0 (index 1), which is cleared by writing one to it. irq is high only while that bit, done enable (index 2 bit 1) and global enable (index 2 bit 0) are all set.
- R12: The control word reads with bit 31 at one while a transaction runs and at zero once it ends.
- R13: Writing zero to the control word during a transaction returns all strobes to idle on the next cycle and releases the chip enable, without setting the done bit.
- R14: cle and ale are never high together, weN and reN are never low together, and at most one chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| ceN | output | 8 | Chip enables, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| weN | output | 1 | Write strobe, active low |
| reN | output | 1 | Read strobe, active low |
| dqOut | output | 8 | Data bus out |
| dqOe | output | 1 | Data bus output enable |
| dqIn | input | 8 | Data bus in |
| rbPin | input | 1 | Ready/busy pin, high when ready |

## Verification
The assertions check on every cycle that the strobes stay exclusive, that at most one chip enable is active, and that an abort returns the pins to idle. They also check that a completion pulse sets the done flag, that a start makes the sequencer busy, and that the interrupt never rises unless both enables are set. Only the bench scenarios can show which byte values go out, in what order, and under which latch enable. The same holds for how bytes are packed on receive, for the strobe widths and phase gaps measured in cycles, and for how the ready wait behaves with the pin compared with status polling.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int CW_START  = 31;
  localparam int CW_LEAD   = 30;
  localparam int CW_ADDR   = 29;
  localparam int CW_DATA   = 28;
  localparam int CW_SEND   = 27;
  localparam int CW_RECV   = 26;
  localparam int CW_TRAIL  = 25;
  localparam int CW_LATE   = 24;
  localparam int CW_READY  = 16;

  localparam logic [3:0] RI_CTRL   = 4'd0;
  localparam logic [3:0] RI_STAT   = 4'd1;
  localparam logic [3:0] RI_IEN    = 4'd2;
  localparam logic [3:0] RI_TIME   = 4'd3;
  localparam logic [3:0] RI_LEAD   = 4'd4;
  localparam logic [3:0] RI_TRAIL  = 4'd5;
  localparam logic [3:0] RI_ADRLO  = 4'd6;
  localparam logic [3:0] RI_ADRHI  = 4'd7;
  localparam logic [3:0] RI_RESP   = 4'd8;
  localparam logic [3:0] RI_MATCH  = 4'd9;

  typedef enum logic [2:0] {
    PH_NONE, PH_LEAD, PH_ADDR, PH_TRAILA, PH_DATA, PH_TRAILB, PH_WAIT, PH_END
  } phase_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_WLOW, ST_WHIGH, ST_RLOW, ST_RHIGH, ST_GAP, ST_WB, ST_BUSY
  } state_e;

  typedef struct packed {
    logic       busy;
    phase_e     phase;
    logic [3:0] idx;
    logic       capture;
    logic       doneSet;
  } seq_ctl_t;
endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int TIMER_W = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        abort,
  input  logic [31:0] cmdWord,
  input  logic [31:0] timing,
  input  logic        pollMode,
  input  logic        pollMatch,
  input  logic        rbPin,
  output seq_ctl_t    ctl,
  output logic        weN,
  output logic        reN,
  output logic        cle,
  output logic        ale,
  output logic        dqOe
);
  state_e state;
  phase_e phase, nxtPh, launchPh;
  logic [TIMER_W-1:0] cnt, launchCnt;
  logic [3:0] idx, lastIdx;
  logic [7:0] phEn;
  state_e launchState;
  logic advance, cntZero, writeOn, cmdPh;

  function automatic logic [TIMER_W-1:0] fld(input logic [3:0] f, input int add);
    return TIMER_W'(f) + TIMER_W'(add);
  endfunction

  always_comb begin
    phEn = '0;
    phEn[PH_LEAD]   = cmdWord[CW_LEAD];
    phEn[PH_ADDR]   = cmdWord[CW_ADDR];
    phEn[PH_TRAILA] = cmdWord[CW_TRAIL] & ~cmdWord[CW_LATE];
    phEn[PH_DATA]   = cmdWord[CW_DATA] & (cmdWord[CW_SEND] | cmdWord[CW_RECV]);
    phEn[PH_TRAILB] = cmdWord[CW_TRAIL] & cmdWord[CW_LATE];
    phEn[PH_WAIT]   = cmdWord[CW_READY];
    phEn[PH_END]    = 1'b1;
    nxtPh = PH_END;
    for (int p = 7; p >= 1; p--) begin
      if (phEn[p] && p > int'(phase)) nxtPh = phase_e'(3'(p));
    end
  end

  always_comb begin
    case (phase)
      PH_LEAD: lastIdx = {2'b00, cmdWord[5:4]};
      PH_ADDR: lastIdx = cmdWord[3:0];
      PH_DATA: lastIdx = (cmdWord[23:20] > 4'd3) ? 4'd3 : cmdWord[23:20];
      default: lastIdx = 4'd0;
    endcase
  end

  always_comb begin
    launchPh = nxtPh;
    case (nxtPh)
      PH_LEAD, PH_ADDR, PH_TRAILA, PH_TRAILB: begin
        launchState = ST_WLOW; launchCnt = fld(timing[3:0], 0);
      end
      PH_DATA: begin
        launchState = ST_GAP;
        launchCnt = cmdWord[CW_SEND] ? fld(timing[31:28], 2) : fld(timing[27:24], 2);
      end
      PH_WAIT: begin launchState = ST_WB; launchCnt = fld(timing[19:16], 0); end
      default: begin launchState = ST_IDLE; launchCnt = '0; end
    endcase
  end

  assign cntZero = (cnt == '0);
  always_comb begin
    case (state)
      ST_SETUP: advance = cntZero;
      ST_WHIGH: advance = cntZero && (idx == lastIdx);
      ST_RHIGH: advance = cntZero && ((phase == PH_DATA) ? (idx == lastIdx) : pollMatch);
      ST_BUSY:  advance = rbPin;
      default:  advance = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; phase <= PH_NONE; cnt <= '0; idx <= '0;
    end else if (abort) begin
      state <= ST_IDLE; phase <= PH_NONE; cnt <= '0; idx <= '0;
    end else if (advance) begin
      state <= launchState; phase <= launchPh; cnt <= launchCnt; idx <= '0;
    end else begin
      if (!cntZero) cnt <= cnt - 1'b1;
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_SETUP; phase <= PH_NONE; cnt <= fld(timing[23:20], 1);
        end
        ST_WLOW: if (cntZero) begin state <= ST_WHIGH; cnt <= fld(timing[7:4], 0); end
        ST_WHIGH: if (cntZero) begin
          idx <= idx + 1'b1; state <= ST_WLOW; cnt <= fld(timing[3:0], 0);
        end
        ST_GAP: if (cntZero) begin
          state <= cmdWord[CW_SEND] ? ST_WLOW : ST_RLOW;
          cnt <= cmdWord[CW_SEND] ? fld(timing[3:0], 0) : fld(timing[11:8], 0);
        end
        ST_RLOW: if (cntZero) begin state <= ST_RHIGH; cnt <= fld(timing[15:12], 0); end
        ST_RHIGH: if (cntZero) begin
          if (phase == PH_DATA) idx <= idx + 1'b1;
          state <= ST_RLOW; cnt <= fld(timing[11:8], 0);
        end
        ST_WB: if (cntZero) begin
          state <= pollMode ? ST_RLOW : ST_BUSY;
          cnt <= pollMode ? fld(timing[11:8], 0) : '0;
        end
        default: ;
      endcase
    end
  end

  assign writeOn = (state == ST_WLOW) || (state == ST_WHIGH);
  assign cmdPh   = (phase == PH_LEAD) || (phase == PH_TRAILA) || (phase == PH_TRAILB);
  assign weN  = !(state == ST_WLOW);
  assign reN  = !(state == ST_RLOW);
  assign cle  = writeOn && cmdPh;
  assign ale  = writeOn && (phase == PH_ADDR);
  assign dqOe = writeOn;

  assign ctl.busy    = (state != ST_IDLE);
  assign ctl.phase   = phase;
  assign ctl.idx     = idx;
  assign ctl.capture = (state == ST_RLOW) && cntZero;
  assign ctl.doneSet = advance && (nxtPh == PH_END);

  assert_latch_excl_R14: assert property (@(posedge clk) disable iff (!rstN) !(cle && ale));
  assert_strobe_excl_R14: assert property (@(posedge clk) disable iff (!rstN) !(!weN && !reN));
  assert_abort_idle_R13: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> (weN && reN && !cle && !ale && !ctl.busy));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.busy |-> (weN && reN && !cle && !ale && !dqOe));
endmodule

// File: rtl/nand_seq_datapath.sv
module nand_seq_datapath
  import nand_seq_pkg::*;
#(
  parameter int CE_W       = 8,
  parameter int RESP_BYTES = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWe,
  input  logic [3:0]      regAddr,
  input  logic [31:0]     regWdata,
  output logic [31:0]     regRdata,
  input  seq_ctl_t        ctl,
  input  logic [7:0]      dqIn,
  output logic [7:0]      dqOut,
  output logic [CE_W-1:0] ceN,
  output logic            irq,
  output logic            start,
  output logic            abort,
  output logic [31:0]     cmdWord,
  output logic [31:0]     timing,
  output logic            pollMode,
  output logic            pollMatch
);
  logic [31:0] leadReg, trailReg, adrLo, adrHi, matchReg;
  logic [1:0]  ienReg;
  logic        doneFlag;
  logic [7:0]  statusByte;
  logic [7:0]  respLane [RESP_BYTES];
  logic [31:0] respWord;
  logic [CE_W-1:0] ceRaw, cePick;
  logic [63:0] adrBus;
  logic wrCtrl;

  assign wrCtrl = regWe && (regAddr == RI_CTRL);
  assign start  = wrCtrl && regWdata[CW_START] && !ctl.busy;
  assign abort  = wrCtrl && (regWdata == '0) && ctl.busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdWord <= '0; timing <= '0; leadReg <= '0; trailReg <= '0;
      adrLo <= '0; adrHi <= '0; matchReg <= '0; ienReg <= '0; doneFlag <= 1'b0;
      statusByte <= '0;
    end else begin
      if (wrCtrl && !ctl.busy) cmdWord <= regWdata;
      if (regWe) begin
        case (regAddr)
          RI_IEN:   ienReg   <= regWdata[1:0];
          RI_TIME:  timing   <= regWdata;
          RI_LEAD:  leadReg  <= regWdata;
          RI_TRAIL: trailReg <= regWdata;
          RI_ADRLO: adrLo    <= regWdata;
          RI_ADRHI: adrHi    <= regWdata;
          RI_MATCH: matchReg <= regWdata;
          default: ;
        endcase
      end
      if (ctl.doneSet) doneFlag <= 1'b1;
      else if (regWe && regAddr == RI_STAT && regWdata[0]) doneFlag <= 1'b0;
      if (ctl.capture && ctl.phase != PH_DATA) statusByte <= dqIn;
    end
  end

  for (genvar b = 0; b < RESP_BYTES; b++) begin : g_resp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) respLane[b] <= '0;
      else if (ctl.capture && ctl.phase == PH_DATA && ctl.idx == 4'(b)) respLane[b] <= dqIn;
      else if (regWe && regAddr == RI_RESP) respLane[b] <= regWdata[b*8 +: 8];
    end
    assign respWord[b*8 +: 8] = respLane[b];
  end

  assign ceRaw = cmdWord[8 +: CE_W];
  always_comb begin
    cePick = '0;
    for (int i = CE_W - 1; i >= 0; i--) if (ceRaw[i]) cePick = CE_W'(1) << i;
  end
  assign ceN = ctl.busy ? ~cePick : '1;

  assign adrBus = {adrHi, adrLo};
  always_comb begin
    case (ctl.phase)
      PH_LEAD:             dqOut = leadReg[{ctl.idx[1:0], 3'b000} +: 8];
      PH_ADDR:             dqOut = adrBus[{ctl.idx[2:0], 3'b000} +: 8];
      PH_TRAILA, PH_TRAILB: dqOut = trailReg[7:0];
      PH_DATA:             dqOut = respWord[{ctl.idx[1:0], 3'b000} +: 8];
      default:             dqOut = '0;
    endcase
  end

  assign pollMode  = (matchReg[31:24] != '0) || (matchReg[15:8] != '0);
  assign pollMatch = ((statusByte & matchReg[31:24]) == matchReg[23:16]) &&
                     ((statusByte & matchReg[15:8]) == matchReg[7:0]);
  assign irq = doneFlag && ienReg[0] && ienReg[1];

  always_comb begin
    case (regAddr)
      RI_CTRL:  regRdata = {ctl.busy, cmdWord[30:0]};
      RI_STAT:  regRdata = {31'd0, doneFlag};
      RI_IEN:   regRdata = {30'd0, ienReg};
      RI_TIME:  regRdata = timing;
      RI_LEAD:  regRdata = leadReg;
      RI_TRAIL: regRdata = trailReg;
      RI_ADRLO: regRdata = adrLo;
      RI_ADRHI: regRdata = adrHi;
      RI_RESP:  regRdata = respWord;
      RI_MATCH: regRdata = matchReg;
      default:  regRdata = '0;
    endcase
  end

  assert_one_enable_R4: assert property (@(posedge clk) disable iff (!rstN) $onehot0(~ceN));
  assert_done_sets_R11: assert property (@(posedge clk) disable iff (!rstN) ctl.doneSet |=> doneFlag);
  assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (doneFlag && ienReg == 2'b11));
  assert_start_busy_R12: assert property (@(posedge clk) disable iff (!rstN) start |=> ctl.busy);
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int CE_W       = 8,
  parameter int RESP_BYTES = 4,
  parameter int TIMER_W    = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWe,
  input  logic [3:0]      regAddr,
  input  logic [31:0]     regWdata,
  output logic [31:0]     regRdata,
  output logic            irq,
  output logic [CE_W-1:0] ceN,
  output logic            cle,
  output logic            ale,
  output logic            weN,
  output logic            reN,
  output logic [7:0]      dqOut,
  output logic            dqOe,
  input  logic [7:0]      dqIn,
  input  logic            rbPin
);
  seq_ctl_t    ctl;
  logic        start, abort, pollMode, pollMatch;
  logic [31:0] cmdWord, timing;

  nand_seq_ctrl #(.TIMER_W(TIMER_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .abort(abort), .cmdWord(cmdWord),
    .timing(timing), .pollMode(pollMode), .pollMatch(pollMatch), .rbPin(rbPin),
    .ctl(ctl), .weN(weN), .reN(reN), .cle(cle), .ale(ale), .dqOe(dqOe)
  );

  nand_seq_datapath #(.CE_W(CE_W), .RESP_BYTES(RESP_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .ctl(ctl), .dqIn(dqIn), .dqOut(dqOut), .ceN(ceN), .irq(irq),
    .start(start), .abort(abort), .cmdWord(cmdWord), .timing(timing),
    .pollMode(pollMode), .pollMatch(pollMatch)
  );
endmodule

// File: tb/nand_cmd_seq_tb.sv
module nand_cmd_seq_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic regWe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic irq, cle, ale, weN, reN, dqOe, rbPin = 1'b0;
  logic [7:0] ceN, dqOut, dqIn;

  int testsRun = 0, testsFailed = 0, cycles = 0;

  always #10 clk = ~clk;

  nand_cmd_seq u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq), .ceN(ceN), .cle(cle), .ale(ale), .weN(weN),
    .reN(reN), .dqOut(dqOut), .dqOe(dqOe), .dqIn(dqIn), .rbPin(rbPin)
  );

  // flash model and pin monitor
  logic [7:0] rdQueue [0:7];
  int rdPtr = 0;
  assign dqIn = rdQueue[rdPtr & 7];

  logic [7:0] logByte [0:63];
  int logKind [0:63];
  int logGap [0:63];
  int logLow [0:63];
  logic [7:0] logCe [0:63];
  int logCnt = 0, reCnt = 0, reGap0 = -1, weRun = 0, idleRun = 0, pendGap = 0, violations = 0;
  logic prevWe = 1'b1, prevRe = 1'b1;

  always @(negedge clk) begin
    cycles++;
    if (cle && ale) violations++;
    if (!weN && !reN) violations++;
    if (prevWe && !weN) begin pendGap = idleRun; idleRun = 0; end
    else if (prevRe && !reN) begin
      if (reCnt == 0) reGap0 = idleRun;
      idleRun = 0;
    end else if (ceN != 8'hFF && weN && reN) idleRun++;
    if (ceN == 8'hFF) idleRun = 0;
    if (!weN) weRun++;
    if (!prevWe && weN && logCnt < 64) begin
      logByte[logCnt] = dqOut;
      logKind[logCnt] = cle ? 0 : (ale ? 1 : 2);
      logGap[logCnt] = pendGap;
      logLow[logCnt] = weRun;
      logCe[logCnt] = ceN;
      logCnt++;
      weRun = 0;
    end
    if (!prevRe && reN) begin reCnt++; rdPtr++; end
    prevWe = weN;
    prevRe = reN;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic clearLog();
    logCnt = 0; reCnt = 0; rdPtr = 0; reGap0 = -1;
  endtask

  task automatic waitIdle(input string req);
    int n = 0;
    while (ceN != 8'hFF && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) check(req, 32'd1, 32'd0);
    @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] d;
    regRead(4'd0, d);
    check("R1 ctrl", d, 32'h0);
    check("R1 pins", {ceN, 3'b0, weN, reN, cle, ale, irq}, {8'hFF, 3'b0, 1'b1, 1'b1, 3'b000});
  endtask

  task automatic testReadLike();
    logic [31:0] d;
    int n;
    clearLog();
    rdQueue[0] = 8'hA5; rdQueue[1] = 8'h5A; rdQueue[2] = 8'hC3;
    rbPin = 1'b0;
    regWrite(4'd2, 32'h3);
    regWrite(4'd3, 32'h0000_0001);
    regWrite(4'd4, 32'h0000_0000);
    regWrite(4'd5, 32'h0000_0030);
    regWrite(4'd6, 32'h4433_2211);
    regWrite(4'd7, 32'h0000_0055);
    regWrite(4'd8, 32'h0);
    regWrite(4'd0, (32'h1 << 31) | (32'h1 << 30) | (32'h1 << 29) | (32'h1 << 28) |
                   (32'h1 << 26) | (32'h1 << 25) | (32'h1 << 16) | (32'd2 << 20) |
                   (32'h04 << 8) | 32'd4);
    n = 0;
    while (reCnt < 3 && n < 2000) begin @(negedge clk); n++; end
    repeat (50) @(negedge clk);
    regRead(4'd0, d);
    check("R12 busy readback", {31'd0, d[31]}, 32'd1);
    check("R10 pin wait holds", {31'd0, ceN == 8'hFF}, 32'd0);
    rbPin = 1'b1;
    waitIdle("R10 pin release");
    check("R2 byte count", logCnt, 32'd7);
    check("R6 lead", {logKind[0][7:0], logByte[0]}, {8'd0, 8'h00});
    check("R5 addr0", {logKind[1][7:0], logByte[1]}, {8'd1, 8'h11});
    check("R5 addr3", {logKind[4][7:0], logByte[4]}, {8'd1, 8'h44});
    check("R5 addr4", {logKind[5][7:0], logByte[5]}, {8'd1, 8'h55});
    check("R2 trailing", {logKind[6][7:0], logByte[6]}, {8'd0, 8'h30});
    check("R4 select", {24'd0, logCe[0]}, 32'hFB);
    check("R4 held", {24'd0, logCe[6]}, 32'hFB);
    check("R8 reads", reCnt, 32'd3);
    regRead(4'd8, d);
    check("R8 packed", d, 32'h00C3_5AA5);
    regRead(4'd0, d);
    check("R12 cleared", {31'd0, d[31]}, 32'd0);
    regRead(4'd1, d);
    check("R11 done", d, 32'd1);
    check("R11 irq", {31'd0, irq}, 32'd1);
    regWrite(4'd1, 32'd1);
    regRead(4'd1, d);
    check("R11 w1c", {d[30:0], irq}, 32'd0);
    check("R14 exclusive", violations, 32'd0);
  endtask

  task automatic testProgramLike();
    clearLog();
    regWrite(4'd3, 32'h4000_0012);
    regWrite(4'd4, 32'h0000_0080);
    regWrite(4'd5, 32'h0000_0010);
    regWrite(4'd6, 32'h0000_2301);
    regWrite(4'd8, 32'hDDCC_BBAA);
    regWrite(4'd0, (32'h1 << 31) | (32'h1 << 30) | (32'h1 << 29) | (32'h1 << 28) |
                   (32'h1 << 27) | (32'h1 << 25) | (32'h1 << 24) | (32'd3 << 20) |
                   (32'h01 << 8) | 32'd1);
    waitIdle("R3 finish");
    check("R3 count", logCnt, 32'd8);
    check("R5 two addr", {logByte[1], logByte[2]}, {8'h01, 8'h23});
    check("R7 data", {logByte[3], logByte[4], logByte[5], logByte[6]}, 32'hAABB_CCDD);
    check("R7 kind", logKind[3] + logKind[6], 32'd4);
    check("R3 trailing last", {logKind[7][7:0], logByte[7]}, {8'd0, 8'h10});
    check("R9 we low", logLow[0] + logLow[4] * 100, 32'd303);
    check("R9 setup min", logGap[0], 32'd2);
    check("R9 data gap", logGap[3], 32'd9);
    check("R9 byte gap", logGap[4], 32'd2);
    regWrite(4'd1, 32'd1);
  endtask

  task automatic testLeadOnly();
    logic [31:0] d;
    clearLog();
    regWrite(4'd2, 32'h2);
    regWrite(4'd3, 32'h0030_0000);
    regWrite(4'd4, 32'h0000_BEEF);
    regWrite(4'd0, (32'h1 << 31) | (32'h1 << 30) | (32'h80 << 8) | (32'd1 << 4));
    waitIdle("R6 finish");
    check("R6 two lead", logCnt, 32'd2);
    check("R6 order", {logByte[0], logByte[1]}, {8'hEF, 8'hBE});
    check("R2 skipped", logKind[0] + logKind[1], 32'd0);
    check("R9 setup", logGap[0], 32'd5);
    check("R4 top", {24'd0, logCe[0]}, 32'h7F);
    regRead(4'd1, d);
    check("R11 gie off", {d[30:0], irq}, 32'd2);
    regWrite(4'd1, 32'd1);
  endtask

  task automatic testPoll();
    clearLog();
    rbPin = 1'b0;
    rdQueue[0] = 8'h00; rdQueue[1] = 8'h41; rdQueue[2] = 8'h40;
    regWrite(4'd3, 32'h0002_0000);
    regWrite(4'd9, 32'h0100_4040);
    regWrite(4'd4, 32'h0000_0070);
    regWrite(4'd0, (32'h1 << 31) | (32'h1 << 30) | (32'h1 << 16) | (32'h02 << 8));
    waitIdle("R10 poll finish");
    check("R10 polls", reCnt, 32'd3);
    check("R9 busy delay", reGap0, 32'd4);
    check("R10 lead", logByte[0], 32'h70);
    regWrite(4'd9, 32'h0);
    regWrite(4'd1, 32'd1);
  endtask

  task automatic testAbort();
    logic [31:0] d;
    int n = 0;
    clearLog();
    rbPin = 1'b0;
    regWrite(4'd3, 32'h0);
    regWrite(4'd0, (32'h1 << 31) | (32'h1 << 30) | (32'h1 << 16) | (32'h01 << 8));
    while (logCnt < 1 && n < 1000) begin @(negedge clk); n++; end
    repeat (20) @(negedge clk);
    check("R13 busy before", {24'd0, ceN}, 32'hFE);
    regWrite(4'd0, 32'h0);
    check("R13 pins idle", {ceN, weN, reN, cle, ale}, {8'hFF, 4'b1100});
    regRead(4'd0, d);
    check("R13 not busy", {31'd0, d[31]}, 32'd0);
    repeat (10) @(negedge clk);
    regRead(4'd1, d);
    check("R13 no done", d, 32'd0);
    check("R13 stays idle", {24'd0, ceN}, 32'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadLike();
    testProgramLike();
    testLeadOnly();
    testPoll();
    testAbort();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog actual %0d expected below 150000", cycles);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule